// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Dispatcher

This block accepts an interrupt command written by the local processor and turns it into one outgoing interrupt message for a small, fixed group of processors. The command is written in two 32-bit halves. A write to the high half stores the 8-bit destination. A write to the low half carries the vector, the delivery mode, the destination mode, the trigger bits and the destination shorthand, and it starts the dispatch.

The block first checks whether the shorthand and the delivery mode form a legal pair. A legal command becomes a message with an effective delivery mode and a target mask that has one bit per processor. An illegal command raises a one-cycle error and sends nothing. Any request for a level trigger is quietly turned into an edge trigger. The message stays on the outputs until the downstream side accepts it. During that time the block reports itself busy and ignores any new writes to the command word.

Each processor is given an 8-bit physical identifier and an 8-bit logical bit pattern through input ports. The block's own position in the group is fixed by a parameter.

Top module: `ipi_dispatch`

## Requirements
- R1: After reset, `busy`, `msg_valid` and `cmd_err` are 0 and `msg_mask` is all zeros.
- R2: A legal write to the low half while not busy sets `msg_valid` and `busy` from the next cycle. In that cycle `msg_vector` equals the written bits 7:0 and `msg_mode` equals bits 10:8. Delivery mode codes are 000 fixed, 001 lowest priority, 010 SMI, 100 NMI, 101 INIT and 110 start-up.
- R3: With shorthand 00 (none) and bit 11 = 0 (physical), mask bit i is set when the stored destination (bits 31:24 of the high half) equals the identifier of processor i. An identifier that matches no processor gives an all-zero mask, and the message is still sent with no error.
- R4: With shorthand 00 and a physical destination of 0xFF, every mask bit is set.
- R5: With shorthand 00 and bit 11 = 1 (logical), mask bit i is set when the destination ANDed with the logical pattern of processor i is nonzero.
- R6: With shorthand 01 (self), the mask holds only the bit of the issuing processor, whatever the destination says.
- R7: With shorthand 10 (all including self), the mask has every bit set and the destination is ignored.
- R8: With shorthand 11 (all excluding self), the mask has every bit set except the issuing processor's bit. The exception is lowest-priority mode, where the issuing processor's bit is also set. Every non-reserved mode is legal under this shorthand.
- R9: With shorthand 01 or 10, any delivery mode other than fixed raises `cmd_err` for exactly one cycle, in the cycle after the write, and no message is sent.
- R10: Delivery mode codes 011 and 111 are reserved and raise `cmd_err` under every shorthand.
- R11: A command with trigger bit 15 set is still sent, and `msg_trig` always reads 0 (edge).
- R12: While `busy` is 1, the message outputs stay stable until `msg_ready` is sampled high. Writes to either half in that period have no effect. `busy` and `msg_valid` drop in the cycle after the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_lo_we | input | 1 | Write strobe for the low half; starts a dispatch |
| cmd_hi_we | input | 1 | Write strobe for the high half (destination) |
| cmd_wdata | input | 32 | Write data for either half |
| proc_ids | input | NPROC*8 | Physical identifier of each processor, processor i in bits 8i+7:8i |
| proc_lids | input | NPROC*8 | Logical bit pattern of each processor |
| busy | output | 1 | Delivery pending (the read-only status bit 12) |
| msg_valid | output | 1 | Message available downstream |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_vector | output | 8 | Interrupt vector |
| msg_mode | output | 3 | Effective delivery mode |
| msg_trig | output | 1 | Effective trigger, 0 = edge |
| msg_mask | output | NPROC | One-hot-per-processor target mask |
| cmd_err | output | 1 | One-cycle pulse for an illegal command |

## Verification
The assertions assume that the two halves are never written in the same cycle. They also assume that `cmd_wdata` holds known values whenever a write strobe is high. The stimulus meets both conditions. It raises exactly one strobe per cycle, changes inputs only on the falling edge, and always writes the destination one cycle before the low half that uses it. The handshake tests hold `msg_ready` low for several cycles so that the stability and ignored-write properties come into play.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int unsigned VEC_LSB   = 0;
    localparam int unsigned MODE_LSB  = 8;
    localparam int unsigned DLOG_BIT  = 11;
    localparam int unsigned TRIG_BIT  = 15;
    localparam int unsigned SH_LSB    = 18;
    localparam int unsigned DEST_LSB  = 24;

    typedef enum logic [1:0] {
        SH_NONE    = 2'b00,
        SH_SELF    = 2'b01,
        SH_ALL_INC = 2'b10,
        SH_ALL_EXC = 2'b11
    } shorthand_e;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'b000,
        DM_LOWPRI = 3'b001,
        DM_SMI    = 3'b010,
        DM_RSV3   = 3'b011,
        DM_NMI    = 3'b100,
        DM_INIT   = 3'b101,
        DM_START  = 3'b110,
        DM_RSV7   = 3'b111
    } dmode_e;

    typedef struct packed {
        shorthand_e sh;
        logic       trig;
        logic       dst_log;
        dmode_e     mode;
        logic [7:0] vec;
    } cmd_t;

    function automatic cmd_t decode_lo(input logic [31:0] w);
        cmd_t c;
        c.sh      = shorthand_e'(w[SH_LSB +: 2]);
        c.trig    = w[TRIG_BIT];
        c.dst_log = w[DLOG_BIT];
        c.mode    = dmode_e'(w[MODE_LSB +: 3]);
        c.vec     = w[VEC_LSB +: 8];
        return c;
    endfunction

    function automatic logic is_reserved(input dmode_e m);
        return (m == DM_RSV3) || (m == DM_RSV7);
    endfunction

endpackage

// File: rtl/ipi_legal_chk.sv
module ipi_legal_chk
    import ipi_pkg::*;
(
    input  cmd_t cmd,
    output logic legal
);
    always_comb begin
        if (is_reserved(cmd.mode)) begin
            legal = 1'b0;
        end else begin
            case (cmd.sh)
                SH_SELF, SH_ALL_INC: legal = (cmd.mode == DM_FIXED);
                default:             legal = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/ipi_target_sel.sv
module ipi_target_sel
    import ipi_pkg::*;
#(
    parameter int unsigned NPROC    = 4,
    parameter int unsigned SELF_IDX = 0
) (
    input  cmd_t               cmd,
    input  logic [7:0]         dest,
    input  logic [NPROC*8-1:0] ids,
    input  logic [NPROC*8-1:0] lids,
    output logic [NPROC-1:0]   mask
);
    localparam logic [NPROC-1:0] ALL_BITS = {NPROC{1'b1}};
    localparam logic [NPROC-1:0] SELF_BIT = NPROC'(1) << SELF_IDX;

    logic [NPROC-1:0] phys_hit;
    logic [NPROC-1:0] log_hit;

    for (genvar g = 0; g < NPROC; g++) begin : g_proc
        assign phys_hit[g] = (ids[g*8 +: 8] == dest);
        assign log_hit[g]  = |(lids[g*8 +: 8] & dest);
    end

    always_comb begin
        case (cmd.sh)
            SH_NONE: begin
                if (cmd.dst_log)        mask = log_hit;
                else if (dest == 8'hFF) mask = ALL_BITS;
                else                    mask = phys_hit;
            end
            SH_SELF:    mask = SELF_BIT;
            SH_ALL_INC: mask = ALL_BITS;
            default:    mask = (cmd.mode == DM_LOWPRI) ? ALL_BITS : (ALL_BITS & ~SELF_BIT);
        endcase
    end
endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch
    import ipi_pkg::*;
#(
    parameter int unsigned NPROC    = 4,
    parameter int unsigned SELF_IDX = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_lo_we,
    input  logic               cmd_hi_we,
    input  logic [31:0]        cmd_wdata,
    input  logic [NPROC*8-1:0] proc_ids,
    input  logic [NPROC*8-1:0] proc_lids,
    output logic               busy,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [7:0]         msg_vector,
    output logic [2:0]         msg_mode,
    output logic               msg_trig,
    output logic [NPROC-1:0]   msg_mask,
    output logic               cmd_err
);
    localparam logic [NPROC-1:0] SELF_BIT = NPROC'(1) << SELF_IDX;

    cmd_t             cmd_in;
    logic             legal;
    logic [NPROC-1:0] mask_d;
    logic [7:0]       dest_q;
    logic             pend_q;
    logic             err_q;
    logic [7:0]       vec_q;
    dmode_e           mode_q;
    logic [NPROC-1:0] mask_q;

    assign cmd_in = decode_lo(cmd_wdata);

    ipi_legal_chk u_legal (
        .cmd   (cmd_in),
        .legal (legal)
    );

    ipi_target_sel #(.NPROC(NPROC), .SELF_IDX(SELF_IDX)) u_sel (
        .cmd  (cmd_in),
        .dest (dest_q),
        .ids  (proc_ids),
        .lids (proc_lids),
        .mask (mask_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dest_q <= '0;
            pend_q <= 1'b0;
            err_q  <= 1'b0;
            vec_q  <= '0;
            mode_q <= DM_FIXED;
            mask_q <= '0;
        end else begin
            err_q <= 1'b0;
            if (!pend_q) begin
                if (cmd_hi_we) dest_q <= cmd_wdata[DEST_LSB +: 8];
                if (cmd_lo_we) begin
                    if (legal) begin
                        pend_q <= 1'b1;
                        vec_q  <= cmd_in.vec;
                        mode_q <= cmd_in.mode;
                        mask_q <= mask_d;
                    end else begin
                        err_q  <= 1'b1;
                    end
                end
            end else if (msg_ready) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign busy       = pend_q;
    assign msg_valid  = pend_q;
    assign msg_vector = vec_q;
    assign msg_mode   = mode_q;
    assign msg_trig   = 1'b0;
    assign msg_mask   = mask_q;
    assign cmd_err    = err_q;

    p_start_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(msg_valid) |-> $past(cmd_lo_we));

    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector)
                                       && $stable(msg_mode) && $stable(msg_mask)));

    p_edge_r11: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> !msg_trig);

    p_err_nomsg_r9: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> !msg_valid);

    p_self_mask_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_lo_we && !busy && cmd_wdata[19:18] == 2'b01 && cmd_wdata[10:8] == 3'b000)
        |=> (msg_valid && msg_mask == SELF_BIT));

    p_err_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        cmd_err |=> !cmd_err);
endmodule

// File: tb/tb_ipi_dispatch.sv
module tb_ipi_dispatch;
    localparam int NPROC = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_lo_we = 1'b0;
    logic              cmd_hi_we = 1'b0;
    logic [31:0]       cmd_wdata = '0;
    logic [NPROC*8-1:0] proc_ids  = {8'h43, 8'h32, 8'h21, 8'h10};
    logic [NPROC*8-1:0] proc_lids = {8'h08, 8'h04, 8'h02, 8'h01};
    logic              busy, msg_valid, msg_trig, cmd_err;
    logic              msg_ready = 1'b0;
    logic [7:0]        msg_vector;
    logic [2:0]        msg_mode;
    logic [NPROC-1:0]  msg_mask;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ipi_dispatch #(.NPROC(NPROC), .SELF_IDX(0)) dut (
        .clk(clk), .rst(rst), .cmd_lo_we(cmd_lo_we), .cmd_hi_we(cmd_hi_we),
        .cmd_wdata(cmd_wdata), .proc_ids(proc_ids), .proc_lids(proc_lids),
        .busy(busy), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_vector(msg_vector), .msg_mode(msg_mode), .msg_trig(msg_trig),
        .msg_mask(msg_mask), .cmd_err(cmd_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [7:0] vec, input logic [2:0] mode,
                                       input logic lg, input logic trig, input logic [1:0] sh);
        return {12'h0, sh, 2'b00, trig, trig, 1'b0, 1'b0, lg, mode, vec};
    endfunction

    task automatic write_dest(input logic [7:0] dest);
        @(negedge clk);
        cmd_hi_we = 1'b1; cmd_wdata = {dest, 24'h0};
        @(negedge clk);
        cmd_hi_we = 1'b0;
    endtask

    task automatic run_cmd(input string tag, input logic [7:0] dest, input logic [31:0] lo,
                           input logic ok, input logic [3:0] exp_mask);
        write_dest(dest);
        cmd_lo_we = 1'b1; cmd_wdata = lo;
        @(negedge clk);
        cmd_lo_we = 1'b0;
        if (ok) begin
            chk({tag, " valid"}, msg_valid, 1);
            chk({tag, " busy"}, busy, 1);
            chk({tag, " err"}, cmd_err, 0);
            chk({tag, " mask"}, msg_mask, exp_mask);
            chk({tag, " vector"}, msg_vector, lo[7:0]);
            chk({tag, " mode"}, msg_mode, lo[10:8]);
            chk({tag, " trig R11"}, msg_trig, 0);
            msg_ready = 1'b1;
            @(negedge clk);
            msg_ready = 1'b0;
            chk({tag, " done R12"}, msg_valid, 0);
        end else begin
            chk({tag, " err"}, cmd_err, 1);
            chk({tag, " nomsg"}, msg_valid, 0);
            @(negedge clk);
            chk({tag, " err pulse"}, cmd_err, 0);
        end
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 valid", msg_valid, 0);
        chk("R1 err", cmd_err, 0);
        chk("R1 mask", msg_mask, 0);
    endtask

    task automatic t_physical();
        run_cmd("R2 R3 phys", 8'h32, mk(8'h41, 3'b000, 0, 0, 2'b00), 1, 4'b0100);
        run_cmd("R3 miss", 8'h77, mk(8'h42, 3'b100, 0, 0, 2'b00), 1, 4'b0000);
        run_cmd("R4 bcast", 8'hFF, mk(8'h43, 3'b101, 0, 0, 2'b00), 1, 4'b1111);
        run_cmd("R5 logical", 8'h0A, mk(8'h44, 3'b001, 1, 0, 2'b00), 1, 4'b1010);
    endtask

    task automatic t_shorthand();
        run_cmd("R6 self", 8'h43, mk(8'h50, 3'b000, 0, 0, 2'b01), 1, 4'b0001);
        run_cmd("R7 allinc", 8'h00, mk(8'h51, 3'b000, 1, 0, 2'b10), 1, 4'b1111);
        run_cmd("R8 allexc", 8'h10, mk(8'h52, 3'b000, 0, 0, 2'b11), 1, 4'b1110);
        run_cmd("R8 allexc lowpri", 8'h10, mk(8'h53, 3'b001, 0, 0, 2'b11), 1, 4'b1111);
        run_cmd("R8 allexc start", 8'h10, mk(8'h54, 3'b110, 0, 0, 2'b11), 1, 4'b1110);
    endtask

    task automatic t_illegal();
        run_cmd("R9 self nmi", 8'h10, mk(8'h60, 3'b100, 0, 0, 2'b01), 0, 4'b0);
        run_cmd("R9 allinc init", 8'h10, mk(8'h61, 3'b101, 0, 0, 2'b10), 0, 4'b0);
        run_cmd("R10 rsv3", 8'h10, mk(8'h62, 3'b011, 0, 0, 2'b00), 0, 4'b0);
        run_cmd("R10 rsv7", 8'h10, mk(8'h63, 3'b111, 0, 0, 2'b11), 0, 4'b0);
    endtask

    task automatic t_level();
        run_cmd("R11 level", 8'h21, mk(8'h70, 3'b000, 0, 1, 2'b00), 1, 4'b0010);
    endtask

    task automatic t_busy();
        write_dest(8'h21);
        cmd_lo_we = 1'b1; cmd_wdata = mk(8'h80, 3'b000, 0, 0, 2'b00);
        @(negedge clk);
        cmd_lo_we = 1'b0;
        cmd_hi_we = 1'b1; cmd_wdata = {8'hFF, 24'h0};
        @(negedge clk);
        cmd_hi_we = 1'b0;
        cmd_lo_we = 1'b1; cmd_wdata = mk(8'h81, 3'b100, 0, 0, 2'b10);
        @(negedge clk);
        cmd_lo_we = 1'b0;
        @(negedge clk);
        chk("R12 held valid", msg_valid, 1);
        chk("R12 held vector", msg_vector, 8'h80);
        chk("R12 held mode", msg_mode, 3'b000);
        chk("R12 held mask", msg_mask, 4'b0010);
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
        chk("R12 cleared", busy, 0);
        // The destination write made while busy must not have taken effect.
        cmd_lo_we = 1'b1; cmd_wdata = mk(8'h82, 3'b000, 0, 0, 2'b00);
        @(negedge clk);
        cmd_lo_we = 1'b0;
        chk("R12 dest kept", msg_mask, 4'b0010);
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_physical();
        t_shorthand();
        t_illegal();
        t_level();
        t_busy();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule